// File: doc/BRIEF.md
# Round-Robin Cache Line Allocator with Split-Dirty Writeback

This block manages one set of a data cache: its tags, valid bits, two dirty bits per line and the line data. Each request looks the set up. A hit returns the addressed word for a load, or writes the word for a store. Hits are serviced even while the cache is switched off. A miss opens a new line only when the access is cacheable. The access is cacheable when translation is on, the page is marked cacheable and the cache is on. A store miss also needs the page's write-allocate attribute.

The line that receives the fill is taken from a round-robin pointer. If that victim holds a valid line, each of its two halves that is dirty is written back as its own four-word burst. The lower half always goes first. Clean halves are skipped. The block then takes the eight fill words in ascending order from the fill port and writes them into the line. Only after the eighth word is the line marked valid, under its new tag, with both dirty bits clear.

The requester keeps the miss pending while the block is busy. It presents the access again once `req_ready` returns.

Top module: `rr_line_alloc`

## Requirements
- R1: `resp_cacheable` is high exactly when `mmu_on`, `cache_on` and `attr_cacheable` are all high.
- R2: While idle, a lookup whose tag matches a valid line raises `resp_hit`. A load hit presents the addressed word on `resp_rdata` in the same cycle. A store hit writes `req_wdata` into the word. Both work whatever the value of `cache_on`, and at most one line matches.
- R3: `fill_req` pulses, starting an allocation, only on a miss that is cacheable and is either a load or a store with `attr_wralloc` high. Any other miss changes neither the lines nor the pointer.
- R4: The victim is the line named by the round-robin pointer. While idle, `alloc_way` shows the pointer. The pointer advances by one per allocation, wraps from 31 to 0, and resets to 0.
- R5: A valid victim with its lower-half dirty bit set (words 0 to 3) is written back first. A valid victim with its upper-half dirty bit set (words 4 to 7) is written back next. Each half is a four-beat burst. Clean halves and invalid victims produce no beat.
- R6: Burst beats go in ascending word order, with `wb_word` the word index and `wb_half` = `wb_word[2]`. `wb_tag` is the victim's old tag, and `wb_last` is high on the fourth beat. A beat is held steady until `wb_ready` is high.
- R7: `fill_ready` stays low until every writeback beat has been taken. Fill words are then written into words 0 to 7 in order, one per cycle in which `fill_valid` is high.
- R8: `req_ready` is low from the allocation request until the eighth fill word. After that word the line holds the new tag, is valid, has both dirty bits clear and returns the filled data.
- R9: A store hit sets the dirty bit of the half that holds the word: bit 2 of `req_word` selects the half.
- R10: After reset every line is invalid, the pointer is 0, `req_ready` is high and no burst or fill is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_tag | input | 20 | Tag of the access |
| req_word | input | 3 | Word index within the line |
| req_wdata | input | 32 | Store data |
| mmu_on | input | 1 | Address translation enabled |
| cache_on | input | 1 | Data cache enabled |
| attr_cacheable | input | 1 | Page cacheable attribute |
| attr_wralloc | input | 1 | Page write-allocate attribute |
| req_ready | output | 1 | Block idle and accepting lookups |
| resp_hit | output | 1 | Lookup hit |
| resp_rdata | output | 32 | Word read on a hit |
| resp_cacheable | output | 1 | Access is cacheable |
| fill_req | output | 1 | Allocation started; external line read needed |
| alloc_way | output | 5 | Pointer when idle, victim line while busy |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | 32 | Fill word |
| fill_ready | output | 1 | Fill words accepted |
| wb_valid | output | 1 | Writeback beat present |
| wb_ready | input | 1 | Writeback beat taken |
| wb_tag | output | 20 | Tag of the line being written back |
| wb_half | output | 1 | Half being written back |
| wb_word | output | 3 | Word index of the beat |
| wb_data | output | 32 | Beat data |
| wb_last | output | 1 | Final beat of the burst |

## Verification
The hardest case to reach is a victim whose dirty bits are in one particular state: lower half only, upper half only, or both. The victim is picked by the pointer, not by the requester, so the right line has to be dirtied before the pointer comes back to it. The stimulus first fills all 32 lines. It then dirties chosen halves of lines 0, 2 and 3 with store hits and leaves line 1 clean. Four fresh misses then wrap the pointer onto those lines in turn. Random traffic then follows: a small pool of tags, mixed loads and stores, and mostly-cacheable settings. This produces further wraps over dirty lines, while `wb_ready` and `fill_valid` are paused at random.

// File: rtl/rla_pkg.sv
package rla_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WB   = 2'd1,
      ST_FILL = 2'd2
   } rla_state_e;
endpackage

// File: rtl/rla_rr.sv
module rla_rr #(
   parameter int WAYS = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step,
   output logic [$clog2(WAYS)-1:0]  ptr
);
   localparam int WAY_W = $clog2(WAYS);
   localparam bit POW2  = ((WAYS & (WAYS - 1)) == 0);

   logic [WAY_W-1:0] nxt;

   generate
      if (POW2) begin : g_wrap_free
         assign nxt = ptr + WAY_W'(1);
      end else begin : g_wrap_cmp
         assign nxt = (ptr == WAY_W'(WAYS - 1)) ? '0 : ptr + WAY_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else if (step) ptr <= nxt;
   end

   // R4
   rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (ptr == (($past(ptr) == WAY_W'(WAYS - 1)) ? '0 : $past(ptr) + WAY_W'(1))));
   // R4
   rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(ptr));
endmodule

// File: rtl/rla_hit.sv
module rla_hit #(
   parameter int WAYS  = 32,
   parameter int TAG_W = 20
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [WAYS-1:0][TAG_W-1:0]   tags,
   input  logic [WAYS-1:0]              valid,
   input  logic [TAG_W-1:0]             tag,
   output logic                         hit_any,
   output logic [$clog2(WAYS)-1:0]      hit_way
);
   localparam int WAY_W = $clog2(WAYS);

   logic [WAYS-1:0] hit_vec;

   generate
      for (genvar g = 0; g < WAYS; g++) begin : g_cmp
         assign hit_vec[g] = valid[g] && (tags[g] == tag);
      end
   endgenerate

   always_comb begin
      hit_way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (hit_vec[i]) hit_way = hit_way | WAY_W'(i);
      end
   end

   assign hit_any = |hit_vec;

   // R2
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/rla_array.sv
module rla_array #(
   parameter int WAYS  = 32,
   parameter int WORDS = 8,
   parameter int DW    = 32,
   parameter int TAG_W = 20
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [$clog2(WAYS)-1:0]       wr_way,
   input  logic [$clog2(WORDS)-1:0]      wr_word,
   input  logic [DW-1:0]                 wr_data,
   input  logic                          dset_en,
   input  logic [$clog2(WAYS)-1:0]       dset_way,
   input  logic                          dset_half,
   input  logic                          inv_en,
   input  logic [$clog2(WAYS)-1:0]       inv_way,
   input  logic                          com_en,
   input  logic [$clog2(WAYS)-1:0]       com_way,
   input  logic [TAG_W-1:0]              com_tag,
   input  logic [$clog2(WAYS)-1:0]       rd0_way,
   input  logic [$clog2(WORDS)-1:0]      rd0_word,
   output logic [DW-1:0]                 rd0_data,
   input  logic [$clog2(WAYS)-1:0]       rd1_way,
   input  logic [$clog2(WORDS)-1:0]      rd1_word,
   output logic [DW-1:0]                 rd1_data,
   output logic [WAYS-1:0][TAG_W-1:0]    tags_q,
   output logic [WAYS-1:0]               valid_q,
   output logic [WAYS-1:0][1:0]          dirty_q
);
   localparam int DEPTH = WAYS * WORDS;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[{wr_way, wr_word}] <= wr_data;
   end

   assign rd0_data = mem[{rd0_way, rd0_word}];
   assign rd1_data = mem[{rd1_way, rd1_word}];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WAYS; i++) begin
            tags_q[i]  <= '0;
            dirty_q[i] <= '0;
         end
         valid_q <= '0;
      end else begin
         if (inv_en) valid_q[inv_way] <= 1'b0;
         if (dset_en) dirty_q[dset_way][dset_half] <= 1'b1;
         if (com_en) begin
            valid_q[com_way] <= 1'b1;
            dirty_q[com_way] <= 2'b00;
            tags_q[com_way]  <= com_tag;
         end
      end
   end
endmodule

// File: rtl/rr_line_alloc.sv
module rr_line_alloc #(
   parameter int WAYS  = 32,
   parameter int WORDS = 8,
   parameter int DW    = 32,
   parameter int TAG_W = 20
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic                      req_store,
   input  logic [TAG_W-1:0]          req_tag,
   input  logic [$clog2(WORDS)-1:0]  req_word,
   input  logic [DW-1:0]             req_wdata,
   input  logic                      mmu_on,
   input  logic                      cache_on,
   input  logic                      attr_cacheable,
   input  logic                      attr_wralloc,
   output logic                      req_ready,
   output logic                      resp_hit,
   output logic [DW-1:0]             resp_rdata,
   output logic                      resp_cacheable,
   output logic                      fill_req,
   output logic [$clog2(WAYS)-1:0]   alloc_way,
   input  logic                      fill_valid,
   input  logic [DW-1:0]             fill_data,
   output logic                      fill_ready,
   output logic                      wb_valid,
   input  logic                      wb_ready,
   output logic [TAG_W-1:0]          wb_tag,
   output logic                      wb_half,
   output logic [$clog2(WORDS)-1:0]  wb_word,
   output logic [DW-1:0]             wb_data,
   output logic                      wb_last
);
   import rla_pkg::*;

   localparam int WAY_W  = $clog2(WAYS);
   localparam int WIX_W  = $clog2(WORDS);
   localparam int BEAT_W = WIX_W - 1;

   generate
      if (WAYS < 2) begin : g_bad_ways
         $error("rr_line_alloc: WAYS must be at least 2");
      end
      if (WORDS < 4 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("rr_line_alloc: WORDS must be a power of two, at least 4");
      end
      if (DW < 1 || TAG_W < 1) begin : g_bad_width
         $error("rr_line_alloc: DW and TAG_W must be positive");
      end
   endgenerate

   rla_state_e        state_q;
   logic [WAY_W-1:0]  victim_q;
   logic [TAG_W-1:0]  newtag_q;
   logic              half_q;
   logic              hi_pend_q;
   logic [WIX_W-1:0]  cnt_q;

   logic [WAY_W-1:0]             rr_ptr;
   logic                         hit_any;
   logic [WAY_W-1:0]             hit_way;
   logic [WAYS-1:0][TAG_W-1:0]   tags_q;
   logic [WAYS-1:0]              valid_q;
   logic [WAYS-1:0][1:0]         dirty_q;

   logic acc, cacheable, alloc_go, st_hit;
   logic need_lo, need_hi;
   logic wb_fire, beat_last, fill_fire, fill_last;

   assign acc       = req_valid && (state_q == ST_IDLE);
   assign cacheable = mmu_on && cache_on && attr_cacheable;
   assign alloc_go  = acc && !hit_any && cacheable && (!req_store || attr_wralloc);
   assign st_hit    = acc && hit_any && req_store;
   assign need_lo   = valid_q[rr_ptr] && dirty_q[rr_ptr][0];
   assign need_hi   = valid_q[rr_ptr] && dirty_q[rr_ptr][1];
   assign beat_last = (cnt_q[BEAT_W-1:0] == {BEAT_W{1'b1}});
   assign wb_fire   = (state_q == ST_WB) && wb_ready;
   assign fill_last = (cnt_q == WIX_W'(WORDS - 1));
   assign fill_fire = (state_q == ST_FILL) && fill_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         victim_q  <= '0;
         newtag_q  <= '0;
         half_q    <= 1'b0;
         hi_pend_q <= 1'b0;
         cnt_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (alloc_go) begin
                  victim_q  <= rr_ptr;
                  newtag_q  <= req_tag;
                  cnt_q     <= '0;
                  hi_pend_q <= need_hi;
                  if (need_lo) begin
                     state_q <= ST_WB;
                     half_q  <= 1'b0;
                  end else if (need_hi) begin
                     state_q <= ST_WB;
                     half_q  <= 1'b1;
                  end else begin
                     state_q <= ST_FILL;
                  end
               end
            end
            ST_WB: begin
               if (wb_fire) begin
                  if (beat_last) begin
                     cnt_q <= '0;
                     if (!half_q && hi_pend_q) half_q <= 1'b1;
                     else state_q <= ST_FILL;
                  end else begin
                     cnt_q <= cnt_q + WIX_W'(1);
                  end
               end
            end
            ST_FILL: begin
               if (fill_valid) begin
                  cnt_q <= cnt_q + WIX_W'(1);
                  if (fill_last) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   rla_rr #(.WAYS(WAYS)) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (alloc_go),
      .ptr   (rr_ptr)
   );

   rla_hit #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
      .clk     (clk),
      .rst_n   (rst_n),
      .tags    (tags_q),
      .valid   (valid_q),
      .tag     (req_tag),
      .hit_any (hit_any),
      .hit_way (hit_way)
   );

   logic [WIX_W-1:0] wb_idx;
   assign wb_idx = {half_q, cnt_q[BEAT_W-1:0]};

   rla_array #(.WAYS(WAYS), .WORDS(WORDS), .DW(DW), .TAG_W(TAG_W)) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (st_hit || fill_fire),
      .wr_way    (st_hit ? hit_way : victim_q),
      .wr_word   (st_hit ? req_word : cnt_q),
      .wr_data   (st_hit ? req_wdata : fill_data),
      .dset_en   (st_hit),
      .dset_way  (hit_way),
      .dset_half (req_word[WIX_W-1]),
      .inv_en    (alloc_go),
      .inv_way   (rr_ptr),
      .com_en    (fill_fire && fill_last),
      .com_way   (victim_q),
      .com_tag   (newtag_q),
      .rd0_way   (hit_way),
      .rd0_word  (req_word),
      .rd0_data  (resp_rdata),
      .rd1_way   (victim_q),
      .rd1_word  (wb_idx),
      .rd1_data  (wb_data),
      .tags_q    (tags_q),
      .valid_q   (valid_q),
      .dirty_q   (dirty_q)
   );

   assign req_ready      = (state_q == ST_IDLE);
   assign resp_hit       = acc && hit_any;
   assign resp_cacheable = cacheable;
   assign fill_req       = alloc_go;
   assign alloc_way      = (state_q == ST_IDLE) ? rr_ptr : victim_q;
   assign fill_ready     = (state_q == ST_FILL);
   assign wb_valid       = (state_q == ST_WB);
   assign wb_tag         = tags_q[victim_q];
   assign wb_half        = half_q;
   assign wb_word        = wb_idx;
   assign wb_last        = wb_valid && beat_last;

   // R3
   alloc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> (resp_cacheable && !resp_hit && req_ready));
   // R6
   wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_word) && $stable(wb_data)));
   // R5
   wb_skip_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !need_lo && !need_hi) |=> fill_ready);
   // R7
   wb_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_ready && wb_last && wb_half) |=> (fill_ready && !wb_valid));
   // R8
   commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_ready && fill_valid && fill_last) |=>
         (valid_q[$past(victim_q)] && (dirty_q[$past(victim_q)] == 2'b00) &&
          (tags_q[$past(victim_q)] == $past(newtag_q)) && req_ready));
endmodule

// File: tb/rr_line_alloc_test.sv
module rr_line_alloc_test;
   localparam int WAYS  = 32;
   localparam int WORDS = 8;
   localparam int DW    = 32;
   localparam int TAG_W = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic             req_valid = 0, req_store = 0;
   logic [TAG_W-1:0] req_tag = '0;
   logic [2:0]       req_word = '0;
   logic [DW-1:0]    req_wdata = '0;
   logic             mmu_on = 1, cache_on = 1, attr_cacheable = 1, attr_wralloc = 0;
   logic             req_ready, resp_hit, resp_cacheable, fill_req, fill_ready;
   logic [DW-1:0]    resp_rdata, wb_data;
   logic [4:0]       alloc_way;
   logic             fill_valid = 0, wb_ready = 0;
   logic [DW-1:0]    fill_data = '0;
   logic             wb_valid, wb_half, wb_last;
   logic [TAG_W-1:0] wb_tag;
   logic [2:0]       wb_word;

   rr_line_alloc #(.WAYS(WAYS), .WORDS(WORDS), .DW(DW), .TAG_W(TAG_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_tag(req_tag), .req_word(req_word), .req_wdata(req_wdata),
      .mmu_on(mmu_on), .cache_on(cache_on), .attr_cacheable(attr_cacheable),
      .attr_wralloc(attr_wralloc), .req_ready(req_ready), .resp_hit(resp_hit),
      .resp_rdata(resp_rdata), .resp_cacheable(resp_cacheable), .fill_req(fill_req),
      .alloc_way(alloc_way), .fill_valid(fill_valid), .fill_data(fill_data),
      .fill_ready(fill_ready), .wb_valid(wb_valid), .wb_ready(wb_ready),
      .wb_tag(wb_tag), .wb_half(wb_half), .wb_word(wb_word), .wb_data(wb_data),
      .wb_last(wb_last)
   );

   bit               mvalid [WAYS];
   logic [TAG_W-1:0] mtag   [WAYS];
   bit               mdirty [WAYS][2];
   logic [DW-1:0]    mdata  [WAYS][WORDS];
   int               mptr = 0;
   int               checks = 0, errors = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int find_way(input logic [TAG_W-1:0] t);
      for (int i = 0; i < WAYS; i++) if (mvalid[i] && mtag[i] == t) return i;
      return -1;
   endfunction

   task automatic service(input int v, input logic [TAG_W-1:0] t);
      for (int h = 0; h < 2; h++) begin
         if (mvalid[v] && mdirty[v][h]) begin
            int beat = 0;
            while (beat < 4) begin
               bit rdy;
               @(negedge clk);
               rdy = ($urandom % 3) != 0;
               wb_ready = rdy;
               fill_valid = 1'b1;
               fill_data = $urandom;
               #1;
               chk("R8", "req_ready during writeback", req_ready, 0);
               chk("R7", "fill_ready during writeback", fill_ready, 0);
               chk("R5", "wb_valid", wb_valid, 1);
               if (rdy) begin
                  chk("R6", "wb_half", wb_half, h);
                  chk("R6", "wb_word", wb_word, h * 4 + beat);
                  chk("R6", "wb_data", wb_data, mdata[v][h * 4 + beat]);
                  chk("R6", "wb_tag", wb_tag, mtag[v]);
                  chk("R6", "wb_last", wb_last, beat == 3);
               end
               @(posedge clk);
               if (rdy) beat++;
            end
         end
      end
      mvalid[v] = 0;
      begin
         int n = 0;
         while (n < WORDS) begin
            bit fv;
            @(negedge clk);
            fv = ($urandom % 4) != 0;
            fill_valid = fv;
            fill_data = $urandom;
            wb_ready = 1'b1;
            #1;
            chk("R7", "fill_ready after writeback", fill_ready, 1);
            chk("R5", "no beat during fill", wb_valid, 0);
            chk("R8", "req_ready during fill", req_ready, 0);
            if (fv) begin
               mdata[v][n] = fill_data;
               n++;
            end
            @(posedge clk);
         end
      end
      @(negedge clk);
      fill_valid = 0;
      wb_ready = 0;
      mvalid[v] = 1;
      mtag[v] = t;
      mdirty[v][0] = 0;
      mdirty[v][1] = 0;
      #1;
      chk("R8", "req_ready after eighth word", req_ready, 1);
      chk("R4", "pointer advanced", alloc_way, mptr);
   endtask

   task automatic access(input bit st, input logic [TAG_W-1:0] t, input int wd,
                         input logic [DW-1:0] d, input bit mmu, input bit cen,
                         input bit attr, input bit wal);
      int  w;
      bit  ehit, ec, ealloc;
      @(negedge clk);
      req_valid = 1; req_store = st; req_tag = t; req_word = 3'(wd); req_wdata = d;
      mmu_on = mmu; cache_on = cen; attr_cacheable = attr; attr_wralloc = wal;
      #1;
      w = find_way(t);
      ehit = (w >= 0);
      ec = mmu && cen && attr;
      ealloc = !ehit && ec && (!st || wal);
      chk("R8", "req_ready idle", req_ready, 1);
      chk("R1", "resp_cacheable", resp_cacheable, ec);
      chk("R2", "resp_hit", resp_hit, ehit);
      if (ehit && !st) chk("R2", "load hit data", resp_rdata, mdata[w][wd]);
      chk("R3", "fill_req", fill_req, ealloc);
      chk("R4", "alloc_way shows pointer", alloc_way, mptr);
      @(posedge clk);
      #1;
      req_valid = 0;
      if (ehit && st) begin
         mdata[w][wd] = d;
         mdirty[w][wd / 4] = 1;   // R9: word bit 2 picks the half
      end
      if (ealloc) begin
         int v = mptr;
         mptr = (mptr + 1) % WAYS;
         service(v, t);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5c));
      for (int i = 0; i < WAYS; i++) begin
         mvalid[i] = 0; mtag[i] = '0; mdirty[i][0] = 0; mdirty[i][1] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      // R10 reset state
      chk("R10", "req_ready", req_ready, 1);
      chk("R10", "pointer", alloc_way, 0);
      chk("R10", "wb_valid", wb_valid, 0);
      chk("R10", "fill_ready", fill_ready, 0);
      // R10: lookup after reset misses; non-cacheable so nothing allocates
      access(0, 20'h00007, 0, 0, 0, 1, 1, 0);

      // fill every line with clean data
      for (int i = 0; i < WAYS; i++) access(0, TAG_W'(i + 1), 0, 0, 1, 1, 1, 0);

      // R9: dirty chosen halves; line 1 left clean
      access(1, 20'd1, 2, 32'hA0A0_0002, 1, 1, 1, 0);
      access(1, 20'd1, 6, 32'hA0A0_0006, 1, 1, 1, 0);
      access(1, 20'd3, 1, 32'hB0B0_0001, 1, 1, 1, 0);
      access(1, 20'd4, 7, 32'hC0C0_0007, 1, 1, 1, 0);
      access(0, 20'd1, 6, 0, 1, 1, 1, 0);
      // R4 wrap to line 0, R5 both halves / none / lower only / upper only
      access(0, 20'd600, 0, 0, 1, 1, 1, 0);
      access(0, 20'd601, 0, 0, 1, 1, 1, 0);
      access(1, 20'd602, 0, 32'h1, 1, 1, 1, 1);
      access(0, 20'd603, 0, 0, 1, 1, 1, 0);
      // R8 refilled line returns its data
      access(0, 20'd600, 5, 0, 1, 1, 1, 0);

      // R2 cache disabled: hits still served, misses never allocate
      access(0, 20'd5, 0, 0, 1, 0, 1, 0);
      access(1, 20'd5, 3, 32'hDEAD_0003, 1, 0, 1, 1);
      access(0, 20'd5, 3, 0, 1, 0, 1, 0);
      access(0, 20'd700, 0, 0, 1, 0, 1, 0);
      access(1, 20'd701, 0, 0, 1, 0, 1, 1);
      // R3 non-cacheable and no-write-allocate misses
      access(0, 20'd702, 0, 0, 0, 1, 1, 0);
      access(0, 20'd703, 0, 0, 1, 1, 0, 0);
      access(1, 20'd704, 0, 0, 1, 1, 1, 0);
      access(0, 20'd704, 0, 0, 1, 1, 1, 0);

      // constrained random traffic
      for (int k = 0; k < 500; k++) begin
         bit st  = $urandom % 2;
         bit all = ($urandom % 6) != 0;
         logic [TAG_W-1:0] t = (($urandom % 5) == 0) ? TAG_W'(1 + $urandom % 32)
                                                     : TAG_W'(100 + $urandom % 40);
         access(st, t, $urandom % 8, $urandom,
                all ? 1'b1 : 1'($urandom), all ? 1'b1 : 1'($urandom),
                all ? 1'b1 : 1'($urandom), 1'($urandom));
      end

      summary();
      $finish;
   end
endmodule